// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo serial audio stream into parallel samples. Three lines come in: a bit clock, a left/right word clock and a data line. All three are oversampled by the system clock. On each rising edge of the bit clock the block takes one data bit. It places bits into channels by watching where the word clock changes level.

One datapath handles three framings:

- **Right-justified.** The last bit of a channel falls just before the word-clock change. The start of the word therefore depends on the word length.
- **Left-justified.** The first bit after the change is the MSB.
- **I2S.** The MSB arrives one bit clock after the change.

Each finished channel is widened to 24 bits with the sample left-aligned, so full scale is kept. After the right channel of a stereo frame completes, the block raises a one-cycle strobe.

The framing and the word length come from a 3-bit code. A separate bit picks which word-clock level means the left channel. The bit clock may run at 32, 48 or 64 times the sample rate, as long as a channel has enough bit periods for the selected format:

- a 16-bit right-justified word needs 16 bit periods;
- a 16-bit I2S word needs 17;
- a 24-bit I2S word needs 25.

Top module: `serial_audio_rx`

## Requirements
- R1: The inputs `sck`, `ws` and `sd` are registered on the system clock. A rising edge of `sck` is seen in the cycle after the first system clock edge that samples it high. A result caused by that bit clock edge is registered on the next system clock edge.
- R2: Format code `fmt`:

  | `fmt` | Framing | Word length |
  |---|---|---|
  | 000 | right-justified | 16 bits |
  | 001 | right-justified | 20 bits |
  | 010 | right-justified | 24 bits |
  | 011 | left-justified | 24 bits |
  | 100 | I2S | 16 bits |
  | 101 | I2S | 24 bits |
  | 110, 111 | reserved | none |

- R3: In right-justified framings a channel's word is the last N bits taken before the word clock changes level, MSB first. Any earlier bits in that channel have no effect on the output.
- R4: In the left-justified framing the bit taken at the first bit clock edge after a word-clock change is the MSB. The word is N bits long, and later bits in the channel have no effect.
- R5: In I2S framings the MSB is the bit taken at the second bit clock edge after a word-clock change. The word is N bits long; the bit at the first edge and the bits after the word have no effect.
- R6: With `ws_pol`=0, the left channel is `ws` high in standard and left-justified framings and `ws` low in I2S framings. With `ws_pol`=1 both conventions are inverted.
- R7: A word of N < 24 bits appears on the 24-bit output with its MSB at bit 23 and zeros in the lowest 24-N bits.
- R8: `smp_valid` is high for exactly one system clock cycle per stereo frame, in the cycle `right_smp` takes the new right word. `left_smp` takes the left word when the left channel completes, and `right_smp` changes at no other time.
- R9: Under a reserved code no strobe is produced and neither output changes.
- R10: Reset clears both outputs and the strobe. No word is reported until at least one word-clock change has been seen since reset, so a channel that was cut by reset is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial bit clock |
| ws | input | 1 | Left/right word clock |
| sd | input | 1 | Serial data, MSB first, two's complement |
| fmt | input | 3 | Framing and word-length code (R2) |
| ws_pol | input | 1 | Word-clock polarity select (R6) |
| left_smp | output | 24 | Last left-channel word, left-aligned |
| right_smp | output | 24 | Last right-channel word, left-aligned |
| smp_valid | output | 1 | One-cycle strobe when a stereo frame completes |

## Verification
A word is due two system clock edges after the system clock first samples the completing bit clock edge high. Depending on the framing, that completing edge is either the edge that shows a word-clock change or the edge that delivers a word's last bit. The bench holds each bit clock phase for three system clocks and drives its inputs on falling clock edges. A monitor therefore reads every strobe on a falling edge, after both outputs have settled, and compares them with words computed in the bench. It also flags a strobe that lasts two cycles. Strobe counts are checked only after the stream has been idle long enough for any pending word to be reported, and one assertion ties each strobe to a bit clock rise exactly two to three cycles earlier.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        ws,
  input  logic        sd,
  input  logic [2:0]  fmt,
  input  logic        ws_pol,
  output logic [23:0] left_smp,
  output logic [23:0] right_smp,
  output logic        smp_valid
);

  logic        b_d1, b_d2, w_d1, d_d1;
  logic        started, locked, prev_ws;
  logic [5:0]  idx;
  logic [23:0] sr;

  wire rise   = b_d1 & ~b_d2;
  wire is_rj  = ~fmt[2] & (fmt[1:0] != 2'b11);
  wire is_lj  = (fmt == 3'b011);
  wire is_i2s = fmt[2] & ~fmt[1];

  logic [5:0] nb;
  always_comb begin
    unique case (fmt)
      3'b000, 3'b100: nb = 6'd16;
      3'b001:         nb = 6'd20;
      default:        nb = 6'd24;
    endcase
  end

  wire        ws_edge  = started & (w_d1 != prev_ws);
  wire [23:0] sr_next  = {sr[22:0], d_d1};
  wire [5:0]  idx_next = ws_edge ? 6'd0 : ((idx == 6'd63) ? idx : idx + 6'd1);
  wire [5:0]  tgt      = nb - 6'd1 + {5'd0, is_i2s};

  wire cap_rj = rise & is_rj & ws_edge & locked;
  wire cap_fj = rise & (is_lj | is_i2s) & (locked | ws_edge) & (idx_next == tgt);
  wire cap    = cap_rj | cap_fj;

  wire        cap_lvl  = cap_rj ? prev_ws : w_d1;
  wire        cap_left = cap_lvl ^ ws_pol ^ is_i2s;
  wire [23:0] word     = cap_rj ? sr : sr_next;

  logic [23:0] aligned;
  always_comb begin
    unique case (nb)
      6'd16:   aligned = {word[15:0], 8'h00};
      6'd20:   aligned = {word[19:0], 4'h0};
      default: aligned = word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_d1      <= 1'b0;
      b_d2      <= 1'b0;
      w_d1      <= 1'b0;
      d_d1      <= 1'b0;
      started   <= 1'b0;
      locked    <= 1'b0;
      prev_ws   <= 1'b0;
      idx       <= 6'd0;
      sr        <= 24'h0;
      left_smp  <= 24'h0;
      right_smp <= 24'h0;
      smp_valid <= 1'b0;
    end else begin
      b_d1      <= sck;
      b_d2      <= b_d1;
      w_d1      <= ws;
      d_d1      <= sd;
      smp_valid <= cap & ~cap_left;
      if (rise) begin
        sr      <= sr_next;
        prev_ws <= w_d1;
        started <= 1'b1;
        idx     <= idx_next;
        if (ws_edge) locked <= 1'b1;
      end
      if (cap && cap_left)  left_smp  <= aligned;
      if (cap && !cap_left) right_smp <= aligned;
    end
  end

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sck,
  input logic [2:0]  fmt,
  input logic [23:0] right_smp,
  input logic        smp_valid
);

  a_r1_strobe_after_sck_rise: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ($past(sck, 2) && !$past(sck, 3)));

  a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  a_r8_right_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(right_smp));

  a_r9_reserved_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ($past(fmt[2:1]) != 2'b11));

  a_r7_zero_fill_16: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && ($past(fmt) == 3'b000 || $past(fmt) == 3'b100)) |-> (right_smp[7:0] == 8'h00));

  a_r7_zero_fill_20: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(fmt) == 3'b001) |-> (right_smp[3:0] == 4'h0));

endmodule

bind serial_audio_rx serial_audio_rx_chk u_chk (.*);

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;
  localparam int CLK_P = 10;
  localparam int BH    = 3;
  localparam int FR    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, ws = 1'b0, sd = 1'b0, ws_pol = 1'b0;
  logic [2:0]  fmt = 3'b000;
  logic [23:0] left_smp, right_smp;
  logic        smp_valid;

  int checks = 0, fails = 0, vcount = 0;
  bit done = 0, pv = 0;
  string tg = "R3";
  logic [23:0] exp_l [FR];
  logic [23:0] exp_r [FR];

  always #(CLK_P/2) clk = ~clk;

  serial_audio_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd), .fmt(fmt),
    .ws_pol(ws_pol), .left_smp(left_smp), .right_smp(right_smp), .smp_valid(smp_valid)
  );

  function automatic logic [23:0] raw(int k, int ch, int r);
    return ((24'(k) * 24'h1357B) + (24'(ch) * 24'h0A5A5) + (24'(r) * 24'h00313)) ^ 24'h5A5A5A;
  endfunction

  function automatic logic [23:0] expect_of(logic [23:0] v, int n);
    return (v << (24 - n));
  endfunction

  // R2: code -> word length and framing (0 right-justified, 1 left-justified, 2 I2S)
  function automatic int nbits(logic [2:0] f);
    return (f == 3'b001) ? 20 : ((f == 3'b000 || f == 3'b100) ? 16 : 24);
  endfunction
  function automatic int kind(logic [2:0] f);
    return f[2] ? 2 : ((f == 3'b011) ? 1 : 0);
  endfunction

  task automatic bitx(input logic w, input logic d);
    sck = 1'b0; ws = w; sd = d;
    repeat (BH) @(negedge clk);
    sck = 1'b1;
    repeat (BH) @(negedge clk);
  endtask

  task automatic send_ch(input logic w, input logic [23:0] word, input int n, input int bpc, input int kd);
    for (int p = 0; p < bpc; p++) begin
      logic d;
      d = (p % 3) != 0;
      if (kd == 0 && p >= bpc - n) d = word[n - 1 - (p - (bpc - n))];
      if (kd == 1 && p < n)        d = word[n - 1 - p];
      if (kd == 2 && p >= 1 && p <= n) d = word[n - p];
      bitx(w, d);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (smp_valid && pv) begin
        checks++; fails++;
        $display("FAIL R8 strobe wider than one cycle: got 2 cycles exp 1");
      end
      if (smp_valid) begin
        if (vcount < FR) begin
          checks++;
          if (left_smp !== exp_l[vcount]) begin
            fails++;
            $display("FAIL %s/R6/R7 left frame %0d got %h exp %h", tg, vcount, left_smp, exp_l[vcount]);
          end
          checks++;
          if (right_smp !== exp_r[vcount]) begin
            fails++;
            $display("FAIL %s/R6/R7 right frame %0d got %h exp %h", tg, vcount, right_smp, exp_r[vcount]);
          end
        end
        vcount++;
      end
      pv = smp_valid;
    end else pv = 0;
  end

  task automatic run(input logic [2:0] f, input logic pol, input int bpc, input int r);
    int n, kd, ecnt;
    logic lvl_l;
    n  = nbits(f);
    kd = kind(f);
    tg = (kd == 0) ? "R3" : ((kd == 1) ? "R4" : "R5");
    ecnt = (f[2:1] == 2'b11) ? 0 : FR;
    lvl_l = 1'b1 ^ pol ^ (kd == 2);
    @(negedge clk);
    rst_n = 1'b0; fmt = f; ws_pol = pol; sck = 1'b0; ws = ~lvl_l; sd = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (left_smp !== 24'h0 || right_smp !== 24'h0 || smp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset state got %h %h %b exp 0 0 0", left_smp, right_smp, smp_valid);
    end
    for (int k = 0; k < FR; k++) begin
      exp_l[k] = expect_of(raw(k, 0, r) & ((24'h1 << n) - 24'h1), n);
      exp_r[k] = expect_of(raw(k, 1, r) & ((24'h1 << n) - 24'h1), n);
    end
    vcount = 0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int p = 0; p < 5; p++) bitx(~lvl_l, 1'b1);   // R10: cut channel, not reported
    for (int k = 0; k < FR; k++) begin
      send_ch(lvl_l,  raw(k, 0, r), n, bpc, kd);
      send_ch(~lvl_l, raw(k, 1, r), n, bpc, kd);
    end
    send_ch(lvl_l, 24'h0, n, bpc, 3);
    repeat (8) @(negedge clk);
    checks++;
    if (vcount != ecnt) begin
      fails++;
      $display("FAIL R2/R8/R9 strobe count fmt %b got %0d exp %0d", f, vcount, ecnt);
    end
    if (ecnt == 0) begin
      checks++;
      if (left_smp !== 24'h0 || right_smp !== 24'h0) begin
        fails++;
        $display("FAIL R9 outputs moved under reserved code got %h %h exp 0 0", left_smp, right_smp);
      end
    end
  endtask

  initial begin
    int r;
    r = 0;
    for (int b = 16; b <= 32; b += 8)
      for (int fi = 0; fi < 6; fi++)
        for (int pl = 0; pl < 2; pl++) begin
          logic [2:0] f;
          f = 3'(fi);
          if (b >= nbits(f) + ((kind(f) == 2) ? 1 : 0)) begin
            run(f, pl[0], b, r);
            r++;
          end
        end
    run(3'b110, 1'b0, 24, 90);   // R9
    run(3'b111, 1'b1, 32, 91);   // R9
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule